// File: doc/BRIEF.md
# Deferred Invalidation Queue with Barrier Drain

This block sits between the coherence fabric and a private cache. Invalidation probes that arrive from the fabric are not applied to the cache tags when they arrive. They are written into a small FIFO and acknowledged in the same cycle. They are then applied to the tag array later, one per cycle, whenever the single cache port is not busy with a line fill. Until a queued invalidation is applied, the cache still holds the old copy of that line, so a read of it returns the old value.

Data replies from the fabric do not wait behind queued probes. Each reply goes straight to the fill path in the cycle it arrives, and it takes priority over the invalidation side for use of the cache port. When the core issues a memory barrier, the block holds the barrier until every probe that was already in the queue has been applied. Probes that arrive after the barrier do not delay it. This is the mechanism that lets a cache see a fresh pointer but stale data unless a barrier is issued between the two reads.

Top module: `probe_queue_drain`

## Requirements
- R1: A probe accepted into an empty queue is not issued toward the cache in the cycle it is accepted. Its invalidation appears on the cache side no earlier than the following cycle.
- R2: The acknowledge output is high in exactly the cycle a probe is accepted, which is any cycle where the probe valid input and the ready output are both high.
- R3: Queued probes are issued as invalidations in arrival order, at most one per cycle, each exactly once.
- R4: No invalidation is issued in a cycle where a fill is being driven. The fill owns the cache port in that cycle.
- R5: A data reply is forwarded to the fill outputs in the cycle it arrives, with its address and data unchanged, whatever the state of the queue.
- R6: When the queue holds DEPTH entries, the ready output is low. A probe offered then is neither acknowledged nor queued, so it never produces an invalidation.
- R7: Barrier done is a one-cycle pulse. It is raised only once every probe that was queued before the barrier request was sampled has been issued. The requester holds the request high until done and lowers it in the next cycle.
- R8: Probes accepted in the cycle the barrier is raised, or later, do not delay that barrier's done.
- R9: A barrier raised while the queue is empty completes one cycle after the request first goes high.
- R10: A reply to a line that still has a probe pending is filled normally. The pending invalidation to that line is still issued afterwards.
- R11: After synchronous reset the queue is empty: ready is high, and no invalidation, fill, acknowledge or barrier done is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prb_valid | input | 1 | Invalidation probe offered by the fabric |
| prb_addr | input | PQ_ADDR_W | Line address of the probe |
| prb_ready | output | 1 | Queue has room for a probe |
| prb_ack | output | 1 | Probe accepted and acknowledged this cycle |
| rpl_valid | input | 1 | Data reply present |
| rpl_addr | input | PQ_ADDR_W | Line address of the reply |
| rpl_data | input | PQ_DATA_W | Reply line data |
| fill_valid | output | 1 | Fill request to the cache |
| fill_addr | output | PQ_ADDR_W | Fill line address |
| fill_data | output | PQ_DATA_W | Fill line data |
| inv_valid | output | 1 | Invalidate request to the cache tags |
| inv_addr | output | PQ_ADDR_W | Line to invalidate |
| bar_req | input | 1 | Memory barrier request from the core |
| bar_done | output | 1 | Barrier complete pulse |

## Verification
The assertions assume that the barrier requester keeps its request high until it sees done and lowers it in the following cycle. They also assume that the cache accepts a fill or an invalidate in the same cycle it is driven, with no stall. The stimulus drives every input just after the rising edge and follows this handshake: each barrier request is released in the cycle after done, and fills are treated as always accepted. Replies are held high for long stretches only to block draining on purpose, so that the queue can be filled to capacity and a barrier can be made to wait on its older probes.

// File: rtl/pq_pkg.sv
package pq_pkg;
    localparam int PQ_ADDR_W = 16;
    localparam int PQ_DATA_W = 32;

    typedef logic [PQ_ADDR_W-1:0] line_addr_t;

    typedef struct packed {
        line_addr_t             addr;
        logic [PQ_DATA_W-1:0]   data;
    } reply_t;

    typedef enum logic {
        BAR_IDLE = 1'b0,
        BAR_WAIT = 1'b1
    } bar_state_e;

    function automatic int ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/pq_fifo.sv
module pq_fifo
    import pq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = ptr_bits(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  line_addr_t       push_addr,
    input  logic             pop,
    output line_addr_t       head_addr,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] occ
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    line_addr_t       slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign empty     = (occ == '0);
    assign full      = (occ == CNT_W'(DEPTH));
    assign head_addr = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_addr;
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) full |-> !push);   // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) empty |-> !pop);   // R3
    AST_OCC_BOUND:    assert property (@(posedge clk) disable iff (rst) occ <= CNT_W'(DEPTH)); // R6
endmodule

// File: rtl/pq_barrier.sv
module pq_barrier
    import pq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bar_req,
    input  logic [CNT_W-1:0] occ,
    input  logic             deq,
    output logic             bar_done
);
    bar_state_e       state;
    logic [CNT_W-1:0] older_left;

    assign bar_done = (state == BAR_WAIT) && (older_left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= BAR_IDLE;
            older_left <= '0;
        end else begin
            case (state)
                BAR_IDLE: if (bar_req) begin
                    state      <= BAR_WAIT;
                    older_left <= occ - CNT_W'(deq);
                end
                BAR_WAIT: begin
                    if (older_left == '0)
                        state <= BAR_IDLE;
                    else if (deq)
                        older_left <= older_left - 1'b1;
                end
                default: state <= BAR_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (rst) bar_done |=> !bar_done); // R7
    AST_OLDER_IN_Q:   assert property (@(posedge clk) disable iff (rst)
                          (state == BAR_WAIT) |-> (older_left <= occ));                        // R8
    AST_EMPTY_FAST:   assert property (@(posedge clk) disable iff (rst)
                          (state == BAR_IDLE && bar_req && occ == '0) |=> bar_done);           // R9
    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) bar_done |-> bar_req); // R7
endmodule

// File: rtl/probe_queue_drain.sv
module probe_queue_drain
    import pq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prb_valid,
    input  logic [PQ_ADDR_W-1:0] prb_addr,
    output logic                 prb_ready,
    output logic                 prb_ack,
    input  logic                 rpl_valid,
    input  logic [PQ_ADDR_W-1:0] rpl_addr,
    input  logic [PQ_DATA_W-1:0] rpl_data,
    output logic                 fill_valid,
    output logic [PQ_ADDR_W-1:0] fill_addr,
    output logic [PQ_DATA_W-1:0] fill_data,
    output logic                 inv_valid,
    output logic [PQ_ADDR_W-1:0] inv_addr,
    input  logic                 bar_req,
    output logic                 bar_done
);
    logic             q_empty, q_full, q_push, q_pop;
    logic [CNT_W-1:0] q_occ;
    line_addr_t       q_head;
    reply_t           rpl;

    // reply path: straight through, never waits on queued probes
    assign rpl        = '{addr: rpl_addr, data: rpl_data};
    assign fill_valid = rpl_valid;
    assign fill_addr  = rpl.addr;
    assign fill_data  = rpl.data;

    // probe acceptance: acknowledged on enqueue
    assign prb_ready = !q_full;
    assign q_push    = prb_valid && prb_ready;
    assign prb_ack   = q_push;

    // cache port arbitration: fill wins
    assign q_pop     = !q_empty && !rpl_valid;
    assign inv_valid = q_pop;
    assign inv_addr  = q_head;

    pq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_addr (prb_addr),
        .pop       (q_pop),
        .head_addr (q_head),
        .empty     (q_empty),
        .full      (q_full),
        .occ       (q_occ)
    );

    pq_barrier #(.CNT_W(CNT_W)) u_bar (
        .clk      (clk),
        .rst      (rst),
        .bar_req  (bar_req),
        .occ      (q_occ),
        .deq      (q_pop),
        .bar_done (bar_done)
    );

    AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) fill_valid |-> !inv_valid); // R4
    AST_ACK_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst) prb_ack |-> $past(q_occ) != CNT_W'(DEPTH) || $past(q_pop)); // R6
    AST_NOT_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
                            (prb_ack && q_empty) |-> !inv_valid);                                   // R1
    AST_DONE_DRAINED:   assert property (@(posedge clk) disable iff (rst)
                            $rose(bar_req) && q_occ == '0 |=> bar_done);                             // R9
endmodule

// File: tb/probe_queue_drain_test.sv
module probe_queue_drain_test;
    import pq_pkg::*;

    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prb_valid = 1'b0;
    logic [PQ_ADDR_W-1:0] prb_addr = '0;
    logic prb_ready, prb_ack;
    logic rpl_valid = 1'b0;
    logic [PQ_ADDR_W-1:0] rpl_addr = '0;
    logic [PQ_DATA_W-1:0] rpl_data = '0;
    logic fill_valid, inv_valid, bar_done;
    logic [PQ_ADDR_W-1:0] fill_addr, inv_addr;
    logic [PQ_DATA_W-1:0] fill_data;
    logic bar_req = 1'b0;

    int checks = 0;
    int errors = 0;
    int inv_since_bar = 0;
    int exp_older = 0;
    int cycles = 0;
    logic [PQ_ADDR_W-1:0] sb [$];

    always #2.5 clk = ~clk;

    probe_queue_drain #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .prb_valid(prb_valid), .prb_addr(prb_addr), .prb_ready(prb_ready), .prb_ack(prb_ack),
        .rpl_valid(rpl_valid), .rpl_addr(rpl_addr), .rpl_data(rpl_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .bar_req(bar_req), .bar_done(bar_done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: scoreboard of invalidations, fill forwarding, barrier completion
    always @(negedge clk) begin
        if (!rst) begin
            if (rpl_valid) begin
                check(fill_valid && fill_addr == rpl_addr && fill_data == rpl_data, "R5",
                      {fill_valid, fill_addr}, {1'b1, rpl_addr});
                check(!inv_valid, "R4", inv_valid, 0);
            end
            if (bar_done)
                check(inv_since_bar == exp_older, "R7/R8 older probes applied", inv_since_bar, exp_older);
            if (inv_valid) begin
                inv_since_bar++;
                if (sb.size() == 0)
                    check(1'b0, "R3/R6 unexpected invalidation", inv_addr, 0);
                else
                    begin
                        logic [PQ_ADDR_W-1:0] e;
                        e = sb.pop_front();
                        check(inv_addr == e, "R3 order", inv_addr, e);
                    end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            finish_run();
        end
    end

    // driver: offer one probe for one cycle, push expectation on acceptance
    task automatic send_probe(input logic [PQ_ADDR_W-1:0] a, input bit exp_acc, input bit fresh_empty);
        @(posedge clk); #1;
        prb_valid = 1'b1;
        prb_addr  = a;
        @(negedge clk);
        check(prb_ack == exp_acc, "R2/R6 ack", prb_ack, exp_acc);
        check(prb_ready == exp_acc, "R6 ready", prb_ready, exp_acc);
        if (fresh_empty) check(!inv_valid, "R1 not same cycle", inv_valid, 0);
        if (prb_ack) sb.push_back(a);
        @(posedge clk); #1;
        prb_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic drain();
        for (int i = 0; i < 50 && sb.size() != 0; i++) @(negedge clk);
        check(sb.size() == 0, "R3 drained", sb.size(), 0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check(prb_ready && !inv_valid && !fill_valid && !prb_ack && !bar_done, "R11 reset",
              {prb_ready, inv_valid, fill_valid, prb_ack, bar_done}, 5'b10000);

        // R1/R2/R3: probes issue one per cycle in arrival order
        send_probe(16'h0100, 1'b1, 1'b1);
        send_probe(16'h0200, 1'b1, 1'b0);
        send_probe(16'h0300, 1'b1, 1'b0);
        drain();

        // R4/R5/R10: reply bypasses queued probe for the same line
        @(posedge clk); #1;
        rpl_valid = 1'b1; rpl_addr = 16'h0AAA; rpl_data = 32'hDEAD_BEEF;
        send_probe(16'h0AAA, 1'b1, 1'b0);
        send_probe(16'h0BBB, 1'b1, 1'b0);
        @(negedge clk);
        check(!inv_valid && fill_addr == 16'h0AAA, "R10 fill delivered while probe pending",
              fill_addr, 16'h0AAA);
        @(posedge clk); #1;
        rpl_valid = 1'b0;
        @(negedge clk);
        check(inv_valid && inv_addr == 16'h0AAA, "R10 later invalidate", inv_addr, 16'h0AAA);
        drain();

        // R6: fill to capacity while replies block draining, extra probe refused
        @(posedge clk); #1;
        rpl_valid = 1'b1; rpl_addr = 16'h1000; rpl_data = 32'h1234_5678;
        for (int i = 0; i < DEPTH; i++) send_probe(16'h2000 + 16'(i), 1'b1, 1'b0);
        send_probe(16'h2FFF, 1'b0, 1'b0);
        @(posedge clk); #1;
        rpl_valid = 1'b0;
        drain();
        idle(2);
        @(negedge clk);
        check(!inv_valid && prb_ready, "R6 refused probe never issued", inv_valid, 0);

        // R7/R8: barrier waits for older probes only
        @(posedge clk); #1;
        rpl_valid = 1'b1; rpl_addr = 16'h3000; rpl_data = 32'h0;
        send_probe(16'h3001, 1'b1, 1'b0);
        send_probe(16'h3002, 1'b1, 1'b0);
        send_probe(16'h3003, 1'b1, 1'b0);
        @(posedge clk); #1;
        bar_req = 1'b1; inv_since_bar = 0; exp_older = 3;
        prb_valid = 1'b1; prb_addr = 16'h3004;
        @(negedge clk);
        check(prb_ack, "R8 younger probe accepted", prb_ack, 1);
        sb.push_back(16'h3004);
        @(posedge clk); #1;
        prb_valid = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(!bar_done, "R7 held while older probes queued", bar_done, 0);
            @(posedge clk); #1;
        end
        rpl_valid = 1'b0;
        begin
            int waited = 0;
            @(negedge clk);
            while (!bar_done && waited < 20) begin
                @(negedge clk);
                waited++;
            end
            check(bar_done, "R7 done reached", bar_done, 1);
            check(sb.size() <= 1, "R8 younger probe did not delay done", sb.size(), 1);
        end
        @(posedge clk); #1;
        bar_req = 1'b0;
        @(negedge clk);
        check(!bar_done, "R7 single pulse", bar_done, 0);
        drain();

        // R9: barrier on empty queue
        @(posedge clk); #1;
        bar_req = 1'b1; inv_since_bar = 0; exp_older = 0;
        @(negedge clk);
        check(!bar_done, "R9 not in raise cycle", bar_done, 0);
        @(negedge clk);
        check(bar_done, "R9 done next cycle", bar_done, 1);
        @(posedge clk); #1;
        bar_req = 1'b0;
        idle(2);
        check(sb.size() == 0, "R3 scoreboard empty", sb.size(), 0);
        finish_run();
    end
endmodule